// File: doc/BRIEF.md
# Weak-Indication Dual-Rail Ripple-Carry Adder

This block adds two W-bit operands and a carry-in. Every value is carried as a dual-rail pair: a true rail and a false rail. Exactly one rail high means a valid bit. Both rails low means a spacer. Both rails high never occurs. The environment presents a full valid codeword and waits until every output is valid. It then returns all inputs to spacer and waits until every output is spacer before it sends the next codeword.

The adder is a chain of one-bit cells. In this clocked model each gate stage costs one clock edge. A cell's carry logic is input-incomplete. When both operand bits agree, the carry is either generated or killed, and it resolves from the operand rails alone. Only when the operand bits differ does the cell wait for the incoming carry. Each carry rail also passes through an operand AND term, so every carry drops to spacer in parallel as soon as the operands go to spacer.

The sum rails are built from holding rendezvous elements (C-elements). A sum rail changes only after all three inputs of its cell are valid, or all three are spacer. The sum rails are therefore the only outputs that confirm the arrival of every input.

Top module: `weakRippleAdder`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released with spacer inputs, every sum and carry-out rail is low.
- R2: Once all outputs are valid, the value on sumT (sumF being its complement), with coutT as bit W, equals A + B + carry-in. Here A is aT and B is bT.
- R3: When the operand bits of a cell are both 1 (generate) or both 0 (kill), that cell's carry is valid one clock edge after the operands, even while the carry-in is spacer. When all bits generate, coutT is high one edge after the operands. When all bits kill, coutF is high one edge after the operands.
- R4: A sum bit stays spacer until its operand bits and its incoming carry are all valid. With every bit propagating (operand bits differ) and the carry-in spacer, all sum and carry-out rails remain low.
- R5: In a propagating cell the carry follows the incoming carry one edge later. With every bit propagating, carry-out becomes valid exactly W edges after the carry-in arrives, and not at edge W-1.
- R6: After all inputs go to spacer, carry-out is spacer after one edge and every sum bit is spacer after two edges, whatever the value of W.
- R7: No sum pair and no carry-out pair ever has both rails high.
- R8: A sum bit keeps its valid value while only some of its inputs have returned to spacer. With the operands at spacer and the carry-in still valid, sum bit 0 holds its value and the other sum bits go to spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge models one gate stage |
| rstN | input | 1 | Asynchronous active-low reset to spacer |
| aT | input | W | Operand A true rails |
| aF | input | W | Operand A false rails |
| bT | input | W | Operand B true rails |
| bF | input | W | Operand B false rails |
| cinT | input | 1 | Carry-in true rail |
| cinF | input | 1 | Carry-in false rail |
| sumT | output | W | Sum true rails |
| sumF | output | W | Sum false rails |
| coutT | output | 1 | Carry-out true rail |
| coutF | output | 1 | Carry-out false rail |

## Verification
The hardest situations to reach from the ports are the partial ones. In these, only some inputs are valid, so the sums must still wait or must hold their value.

The stimulus sets up all-propagate operands and keeps the carry-in at spacer. It then releases the carry-in and counts the edges until carry-out appears. In a separate case it drops the operands to spacer while the carry-in stays valid, which exposes the hold behaviour of the sum elements.

A behavioural model uses three-valued integers per bit and is compared on every clock, so the timing of each ripple is checked as well as the final value.

// File: rtl/weakAdderPkg.sv
package weakAdderPkg;
  // One dual-rail bit: hi = true rail, lo = false rail.
  typedef struct packed {
    logic hi;
    logic lo;
  } railPair_t;

  // Number of three-input rendezvous terms per sum cell.
  localparam int unsigned MINTERMS = 8;
endpackage

// File: rtl/carryChain.sv
module carryChain
  import weakAdderPkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         aT,
  input  logic [W-1:0]         aF,
  input  logic [W-1:0]         bT,
  input  logic [W-1:0]         bF,
  input  logic                 cinT,
  input  logic                 cinF,
  output railPair_t [W-1:0]    carOut
);
  logic [W-1:0] genHi, killLo, propSel, inHi, inLo;

  assign genHi   = aT & bT;
  assign killLo  = aF & bF;
  assign propSel = (aT & bF) | (aF & bT);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      if (i == 0) begin : g_first
        assign inHi[i] = cinT;
        assign inLo[i] = cinF;
      end else begin : g_rest
        assign inHi[i] = carOut[i-1].hi;
        assign inLo[i] = carOut[i-1].lo;
      end

      // The AND with propSel is the redundant input-incomplete path: the carry
      // drops as soon as the operands are spacer, whatever the carry-in does.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          carOut[i] <= '0;
        end else begin
          carOut[i].hi <= genHi[i]  | (propSel[i] & inHi[i]);
          carOut[i].lo <= killLo[i] | (propSel[i] & inLo[i]);
        end
      end
    end
  endgenerate

  logic [W-1:0] carHiVec, carLoVec;
  always_comb begin
    for (int k = 0; k < W; k++) begin
      carHiVec[k] = carOut[k].hi;
      carLoVec[k] = carOut[k].lo;
    end
  end

  // R3
  gen_resolve_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(aT & bT)) & ~carHiVec) == '0));
  // R3
  kill_resolve_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(aF & bF)) & ~carLoVec) == '0));
  // R6
  par_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(aT | aF | bT | bF) == '0) |-> ((carHiVec | carLoVec) == '0));
  // R7
  car_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carHiVec & carLoVec) == '0);
endmodule

// File: rtl/sumBank.sv
module sumBank
  import weakAdderPkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aT,
  input  logic [W-1:0] aF,
  input  logic [W-1:0] bT,
  input  logic [W-1:0] bF,
  input  logic [W-1:0] cT,
  input  logic [W-1:0] cF,
  output logic [W-1:0] sumT,
  output logic [W-1:0] sumF
);
  genvar i, k;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic [MINTERMS-1:0] term;
      for (k = 0; k < MINTERMS; k++) begin : g_term
        // Index bit 2 picks the a rail, bit 1 the b rail, bit 0 the carry rail.
        logic ra, rb, rc;
        assign ra = k[2] ? aT[i] : aF[i];
        assign rb = k[1] ? bT[i] : bF[i];
        assign rc = k[0] ? cT[i] : cF[i];
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                term[k] <= 1'b0;
          else if (ra & rb & rc)    term[k] <= 1'b1;
          else if (!(ra | rb | rc)) term[k] <= 1'b0;
        end
      end
      assign sumT[i] = term[1] | term[2] | term[4] | term[7];
      assign sumF[i] = term[0] | term[3] | term[5] | term[6];

      // R4
      sum_indicate_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(sumT[i] | sumF[i]) |->
          ($past(aT[i] | aF[i]) && $past(bT[i] | bF[i]) && $past(cT[i] | cF[i])));
      // R8
      sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(sumT[i]) && $past(aT[i] | aF[i] | bT[i] | bF[i] | cT[i] | cF[i]))
          |-> sumT[i]);
    end
  endgenerate

  // R7
  sum_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumT & sumF) == '0);
endmodule

// File: rtl/weakRippleAdder.sv
module weakRippleAdder
  import weakAdderPkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aT,
  input  logic [W-1:0] aF,
  input  logic [W-1:0] bT,
  input  logic [W-1:0] bF,
  input  logic         cinT,
  input  logic         cinF,
  output logic [W-1:0] sumT,
  output logic [W-1:0] sumF,
  output logic         coutT,
  output logic         coutF
);
  localparam int unsigned TOP = W - 1;

  railPair_t [W-1:0] carry;
  logic [W-1:0] cellCinT, cellCinF;

  always_comb begin
    cellCinT[0] = cinT;
    cellCinF[0] = cinF;
    for (int k = 1; k < W; k++) begin
      cellCinT[k] = carry[k-1].hi;
      cellCinF[k] = carry[k-1].lo;
    end
  end

  carryChain #(.W(W)) u_chain (
    .clk(clk), .rstN(rstN), .aT(aT), .aF(aF), .bT(bT), .bF(bF),
    .cinT(cinT), .cinF(cinF), .carOut(carry)
  );

  sumBank #(.W(W)) u_sums (
    .clk(clk), .rstN(rstN), .aT(aT), .aF(aF), .bT(bT), .bF(bF),
    .cT(cellCinT), .cF(cellCinF), .sumT(sumT), .sumF(sumF)
  );

  assign coutT = carry[TOP].hi;
  assign coutF = carry[TOP].lo;

  // R7
  cout_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(coutT && coutF));
endmodule

// File: tb/sim_weakRippleAdder.sv
module sim_weakRippleAdder;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aT = '0, aF = '0, bT = '0, bF = '0;
  logic cinT = 1'b0, cinF = 1'b0;
  logic [W-1:0] sumT, sumF;
  logic coutT, coutF;

  int nRun = 0;
  int nFail = 0;
  int mCar[W];
  int mSum[W];

  always #5 clk = ~clk;

  weakRippleAdder #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .aT(aT), .aF(aF), .bT(bT), .bF(bF),
    .cinT(cinT), .cinF(cinF), .sumT(sumT), .sumF(sumF),
    .coutT(coutT), .coutF(coutF)
  );

  function automatic int railVal(logic t, logic f);
    if (t) return 1;
    if (f) return 0;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: three-valued state per bit (-1 = spacer).
  always @(posedge clk) begin
    int oldCar[W];
    for (int i = 0; i < W; i++) oldCar[i] = mCar[i];
    for (int i = 0; i < W; i++) begin
      int a, b, c;
      a = railVal(aT[i], aF[i]);
      b = railVal(bT[i], bF[i]);
      c = (i == 0) ? railVal(cinT, cinF) : oldCar[i-1];
      if (!rstN) begin
        mCar[i] = -1;
        mSum[i] = -1;
      end else begin
        if (a < 0 || b < 0) mCar[i] = -1;
        else if (a == b)    mCar[i] = a;
        else                mCar[i] = c;
        if (a >= 0 && b >= 0 && c >= 0) mSum[i] = (a + b + c) % 2;
        else if (a < 0 && b < 0 && c < 0) mSum[i] = -1;
      end
    end
  end

  // R7 R2: compare the full output state with the model on every clock.
  always @(negedge clk) begin
    if (rstN) begin
      logic [W-1:0] eT, eF;
      for (int i = 0; i < W; i++) begin
        eT[i] = (mSum[i] == 1);
        eF[i] = (mSum[i] == 0);
      end
      chk(sumT == eT && sumF == eF && coutT == (mCar[W-1] == 1) &&
          coutF == (mCar[W-1] == 0), "R7 model",
          {sumT[15:0], sumF[15:0], 30'b0, coutT, coutF},
          {eT[15:0], eF[15:0], 30'b0, mCar[W-1] == 1, mCar[W-1] == 0});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, int c);
    aT = a; aF = ~a; bT = b; bF = ~b;
    cinT = (c == 1); cinF = (c == 0);
  endtask

  task automatic spacer();
    aT = '0; aF = '0; bT = '0; bF = '0; cinT = 1'b0; cinF = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < W; i++) begin mCar[i] = -1; mSum[i] = -1; end
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [W-1:0] pa, pb;
    logic [W:0] ex;
    int pc;
    tick(1);
    // R1 during reset
    chk((sumT | sumF) == '0 && !coutT && !coutF, "R1 in reset",
        {sumT, sumF}, 64'h0);
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk((sumT | sumF) == '0 && !coutT && !coutF, "R1 after release",
        {sumT, sumF}, 64'h0);

    // R4: all propagate, carry-in spacer
    pa = 32'h0F0F_3C3C;
    drive(pa, ~pa, -1);
    tick(W + 2);
    chk((sumT | sumF) == '0, "R4 sums wait", {sumT, sumF}, 64'h0);
    chk(!coutT && !coutF, "R4 cout wait", {coutT, coutF}, 0);
    // R5: carry-in arrives, ripple takes W edges
    cinF = 1'b1;
    tick(W - 1);
    chk(!coutT && !coutF, "R5 not before W", {coutT, coutF}, 0);
    tick(1);
    chk(coutF && !coutT, "R5 at W", {coutT, coutF}, 2'b01);
    chk(sumT == '1 && sumF == '0, "R2 propagate sum", sumT, {W{1'b1}});
    // R6
    spacer();
    tick(1);
    chk(!coutT && !coutF, "R6 cout one edge", {coutT, coutF}, 0);
    tick(1);
    chk((sumT | sumF) == '0, "R6 sums two edges", {sumT, sumF}, 64'h0);

    // R3 generate, carry-in spacer
    drive('1, '1, -1);
    tick(1);
    chk(coutT && !coutF, "R3 generate", {coutT, coutF}, 2'b10);
    spacer(); tick(3);
    // R3 kill, carry-in spacer
    drive('0, '0, -1);
    tick(1);
    chk(coutF && !coutT, "R3 kill", {coutT, coutF}, 2'b01);
    spacer(); tick(3);

    // R8: operands to spacer while the carry-in stays valid
    drive(32'h0000_0001, 32'h0000_0002, 0);
    tick(W + 1);
    chk(sumT == 32'h3, "R2 small sum", sumT, 32'h3);
    aT = '0; aF = '0; bT = '0; bF = '0;
    tick(3);
    chk(sumT[0] && !sumF[0], "R8 bit0 held", {sumT[0], sumF[0]}, 2'b10);
    chk((sumT[W-1:1] | sumF[W-1:1]) == '0, "R8 upper spacer",
        {sumT, sumF}, 64'h0);
    spacer(); tick(3);

    // R2 R6 random operands
    for (int n = 0; n < 150; n++) begin
      pa = $urandom; pb = $urandom; pc = $urandom_range(0, 1);
      if (n % 10 == 0) pb = ~pa;
      drive(pa, pb, pc);
      tick(W + 1);
      ex = {1'b0, pa} + {1'b0, pb} + pc;
      chk({coutT, sumT} == ex && (sumT ^ sumF) == '1 && (coutT ^ coutF),
          "R2 random", {coutT, sumT}, ex);
      spacer();
      tick(2);
      chk((sumT | sumF) == '0 && !coutT && !coutF, "R6 random reset",
          {sumT, sumF}, 64'h0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule